// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of a master-only SPI port. A register front end hands it one word at a time through a one-deep holding register. The engine moves each held word into its shift register and sends it out most significant bit first on the data-out line. At the same time it captures the data-in line into a receive shift register. When a word ends, the received bits are copied into two 16-bit result registers and a one-cycle completion pulse is raised. FIFOs, DMA and interrupt handling live in a separate buffering block that sits between the front end and this engine.

The serial clock is derived from the module clock. A 2-bit select picks one of four division ratios. Polarity and phase are programmable, and so is the word length: 8, 9, 16 or 32 bits. In 9-bit mode the leading bit comes from a configuration bit rather than from the data word. While the engine is idle, or while an override bit is set, the data-out line is held at a programmed level.

Turning the enable bit off stops new words from being accepted, but any word already held or in flight is still sent. A soft-reset input aborts the engine at once. The configuration inputs are left untouched by it, and the data-in synchronizer keeps running.

Top module: `spi_shift_core`

## Requirements
- R1: The word-size code selects how many bits a word carries: 00 gives 8, 01 gives 16, 10 gives 32 and 11 gives 9. A word keeps `busy` high for exactly 2·H·L module clocks, where L is the word length and H is half the division ratio.
- R2: Bits leave on `mosi` most significant bit first. In 9-bit mode the first bit is `cfg_ninth_bit` and the next eight are `tx_lo[7:0]`. In 8-bit mode the word is `tx_lo[7:0]`, in 16-bit mode it is `tx_lo`, and in 32-bit mode it is `{tx_hi, tx_lo}`.
- R3: The clock-divide code sets the serial clock period in module clocks: 00 gives 8, 01 gives 4, 10 gives 2 and 11 gives 14. Each period is split into two equal halves.
- R4: While idle, `sclk` equals `cfg_cpol`. With `cfg_cpha`=0, the first half of each bit sits at the idle level. With `cfg_cpha`=1, the first half sits at the opposite level. In both cases `miso` is sampled at the end of the first half, and `mosi` changes only at bit boundaries.
- R5: `mosi` equals `cfg_idle_do` whenever `busy` is low or `cfg_force_do` is high.
- R6: At the end of a word the received bits are written into the result registers. A 32-bit word fills `rx_hi` (first 16 bits received) and `rx_lo`. A 16-bit word fills `rx_lo`. An 8-bit or 9-bit word writes only `rx_lo[7:0]` with its last eight bits, and `rx_lo[15:8]` keeps its old value.
- R7: `din_level` follows `miso` with a delay of two module clocks. Soft reset does not clear it.
- R8: `tx_ready` is high only when `cfg_enable` is high, the holding register is empty and soft reset is low. After `cfg_enable` falls, a word already held and a word in flight are both still sent in full.
- R9: One cycle after `cfg_soft_rst` is sampled high, `busy`, `done`, `rx_lo` and `rx_hi` are all zero. The holding register is emptied and the serial outputs return to their idle levels.
- R10: `busy` rises one cycle after a word is accepted. `done` pulses for one cycle at the clock edge that ends the last bit-time. A word held while another is shifting starts on that same edge, with no idle gap.
- R11: After the active-low synchronous reset, `busy`, `done`, `rx_lo`, `rx_hi` and `din_level` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Accept new words; low drains pending work |
| cfg_soft_rst | input | 1 | Immediate engine abort, configuration untouched |
| cfg_word_size | input | 2 | Word length code (8/16/32/9) |
| cfg_clk_div | input | 2 | Serial clock divide code (8/4/2/14) |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_idle_do | input | 1 | Data-out level when idle or forced |
| cfg_force_do | input | 1 | Override data-out with the idle level |
| cfg_ninth_bit | input | 1 | Leading bit in 9-bit mode |
| tx_lo | input | 16 | Low half of the word to send |
| tx_hi | input | 16 | High half of the word to send (32-bit mode) |
| tx_valid | input | 1 | Word offered to the holding register |
| tx_ready | output | 1 | Holding register can take a word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A word is in the shift register |
| done | output | 1 | One-cycle pulse when a word ends |
| rx_lo | output | 16 | Low half of the received word |
| rx_hi | output | 16 | High half of the received word |
| din_level | output | 1 | Synchronized level of the data-in pin |

## Verification
The bench runs all four divide codes and all polarity and phase pairs. If a divide ratio were off by one, or a half-period were miscounted, `sclk` and the busy length would drift from the reference model within the first bit. A wrong sampling edge would give received words shifted by one bit. The 9-bit mode is sent with both values of the leading bit; a design that took that bit from the data word would send the wrong first bit. An 8-bit word that follows a 16-bit one shows whether the upper receive byte is kept or overwritten. Back-to-back words, disabling the engine with one word held and one in flight, and a soft reset in the middle of a word expose any gap between words, any dropped drain word, and any state left behind by an abort.

// File: rtl/spi_eng_pkg.sv
// Shared widths, mode encodings and decode helpers for the SPI shift engine.
// Assumes a 16-bit register half and a 32-bit maximum word.
package spi_eng_pkg;

    localparam int HALF_W   = 16;
    localparam int FULL_W   = 2 * HALF_W;
    localparam int BYTE_W   = 8;
    localparam int BITCNT_W = $clog2(FULL_W) + 1;
    localparam int HCNT_W   = 3;

    typedef enum logic [1:0] {
        WS_8  = 2'b00,
        WS_16 = 2'b01,
        WS_32 = 2'b10,
        WS_9  = 2'b11
    } wsize_e;

    typedef enum logic [1:0] {
        DIV_8  = 2'b00,
        DIV_4  = 2'b01,
        DIV_2  = 2'b10,
        DIV_14 = 2'b11
    } div_e;

    // Number of bits in one word for a size code.
    function automatic logic [BITCNT_W-1:0] word_bits(input wsize_e ws);
        case (ws)
            WS_8:    return BITCNT_W'(BYTE_W);
            WS_9:    return BITCNT_W'(BYTE_W + 1);
            WS_16:   return BITCNT_W'(HALF_W);
            default: return BITCNT_W'(FULL_W);
        endcase
    endfunction

    // Last count value of one half serial period (half ratio minus one).
    function automatic logic [HCNT_W-1:0] half_last(input div_e d);
        case (d)
            DIV_8:   return HCNT_W'(3);
            DIV_4:   return HCNT_W'(1);
            DIV_2:   return HCNT_W'(0);
            default: return HCNT_W'(6);
        endcase
    endfunction

    // Places the outgoing word at the top of the shift register.
    function automatic logic [FULL_W-1:0] left_align(input wsize_e ws,
                                                     input logic [HALF_W-1:0] lo,
                                                     input logic [HALF_W-1:0] hi,
                                                     input logic ninth);
        case (ws)
            WS_8:    return {lo[BYTE_W-1:0], {(FULL_W-BYTE_W){1'b0}}};
            WS_9:    return {ninth, lo[BYTE_W-1:0], {(FULL_W-BYTE_W-1){1'b0}}};
            WS_16:   return {lo, {HALF_W{1'b0}}};
            default: return {hi, lo};
        endcase
    endfunction

endpackage

// File: rtl/spi_rate_gen.sv
// Serial bit-timing generator. Counts module clocks in two equal halves
// per bit and flags the end of each half. Assumes clr is held while idle
// so that every word starts at count zero in the first half.
module spi_rate_gen #(
    parameter int HCNT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic [HCNT_W-1:0] half_last,
    output logic              phase_hi,
    output logic              mid_tick,
    output logic              end_tick
);

    logic [HCNT_W-1:0] cnt_q;
    logic              half_q;

    // Advance the half-period counter and toggle the half flag on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else if (run) begin
            if (cnt_q == half_last) begin
                cnt_q  <= '0;
                half_q <= ~half_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign phase_hi = half_q;
    assign mid_tick = run && !half_q && (cnt_q == half_last);
    assign end_tick = run &&  half_q && (cnt_q == half_last);

endmodule

// File: rtl/spi_shift_path.sv
// Transmit and receive shift registers. Transmit shifts left at each bit
// end; receive shifts in at the mid-bit sample point. Assumes load and
// mid_tick never coincide.
module spi_shift_path #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         mid_tick,
    input  logic         end_tick,
    input  logic         miso,
    output logic         tx_bit,
    output logic [W-1:0] rx_bits
);

    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    // Load or shift the outgoing word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_word;
        end else if (end_tick) begin
            tx_q <= {tx_q[W-2:0], 1'b0};
        end
    end

    // Collect incoming bits at each sample point.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || load) begin
            rx_q <= '0;
        end else if (mid_tick) begin
            rx_q <= {rx_q[W-2:0], miso};
        end
    end

    assign tx_bit  = tx_q[W-1];
    assign rx_bits = rx_q;

endmodule

// File: rtl/spi_din_sync.sv
// Multi-stage synchronizer that reports the data-in pin level.
// Cleared only by the module reset. Assumes STAGES >= 2.
module spi_din_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] pipe_q;

    // Shift the pin level through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], din};
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/spi_shift_core.sv
// Master SPI shift engine: one-deep holding register, bit timing, shift
// paths and result registers. Assumes configuration inputs stay static
// while a word is in flight, except for the data-out override.
module spi_shift_core #(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_enable,
    input  logic        cfg_soft_rst,
    input  logic [1:0]  cfg_word_size,
    input  logic [1:0]  cfg_clk_div,
    input  logic        cfg_cpol,
    input  logic        cfg_cpha,
    input  logic        cfg_idle_do,
    input  logic        cfg_force_do,
    input  logic        cfg_ninth_bit,
    input  logic [15:0] tx_lo,
    input  logic [15:0] tx_hi,
    input  logic        tx_valid,
    output logic        tx_ready,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        busy,
    output logic        done,
    output logic [15:0] rx_lo,
    output logic [15:0] rx_hi,
    output logic        din_level
);
    import spi_eng_pkg::*;

    logic                hold_full_q;
    logic [FULL_W-1:0]   hold_word_q;
    wsize_e              hold_ws_q;
    logic [HCNT_W-1:0]   hold_hl_q;
    logic                active_q;
    wsize_e              cur_ws_q;
    logic [HCNT_W-1:0]   cur_hl_q;
    logic [BITCNT_W-1:0] bits_left_q;
    logic [HALF_W-1:0]   rx_lo_q;
    logic [HALF_W-1:0]   rx_hi_q;
    logic                done_q;

    logic                phase_hi;
    logic                mid_tick;
    logic                end_tick;
    logic                tx_bit;
    logic [FULL_W-1:0]   rx_bits;
    logic                accept;
    logic                last_end;
    logic                load_now;

    assign tx_ready = cfg_enable && !hold_full_q && !cfg_soft_rst;
    assign accept   = tx_valid && tx_ready;
    assign last_end = end_tick && (bits_left_q == BITCNT_W'(1));
    assign load_now = hold_full_q && (!active_q || last_end) && !cfg_soft_rst;

    // Capture offered words and release them to the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_soft_rst) begin
            hold_full_q <= 1'b0;
            hold_word_q <= '0;
            hold_ws_q   <= WS_8;
            hold_hl_q   <= '0;
        end else if (accept) begin
            hold_full_q <= 1'b1;
            hold_word_q <= left_align(wsize_e'(cfg_word_size), tx_lo, tx_hi, cfg_ninth_bit);
            hold_ws_q   <= wsize_e'(cfg_word_size);
            hold_hl_q   <= half_last(div_e'(cfg_clk_div));
        end else if (load_now) begin
            hold_full_q <= 1'b0;
        end
    end

    // Track the word in flight and its remaining bit count.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_soft_rst) begin
            active_q    <= 1'b0;
            cur_ws_q    <= WS_8;
            cur_hl_q    <= '0;
            bits_left_q <= '0;
        end else if (load_now) begin
            active_q    <= 1'b1;
            cur_ws_q    <= hold_ws_q;
            cur_hl_q    <= hold_hl_q;
            bits_left_q <= word_bits(hold_ws_q);
        end else if (last_end) begin
            active_q <= 1'b0;
        end else if (end_tick) begin
            bits_left_q <= bits_left_q - 1'b1;
        end
    end

    // Write received bits into the result registers at word end.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_soft_rst) begin
            rx_lo_q <= '0;
            rx_hi_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= last_end;
            if (last_end) begin
                case (cur_ws_q)
                    WS_8, WS_9: rx_lo_q[BYTE_W-1:0] <= rx_bits[BYTE_W-1:0];
                    WS_16:      rx_lo_q <= rx_bits[HALF_W-1:0];
                    default: begin
                        rx_hi_q <= rx_bits[FULL_W-1:HALF_W];
                        rx_lo_q <= rx_bits[HALF_W-1:0];
                    end
                endcase
            end
        end
    end

    spi_rate_gen #(
        .HCNT_W (HCNT_W)
    ) i_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cfg_soft_rst || !active_q),
        .run       (active_q),
        .half_last (cur_hl_q),
        .phase_hi  (phase_hi),
        .mid_tick  (mid_tick),
        .end_tick  (end_tick)
    );

    spi_shift_path #(
        .W (FULL_W)
    ) i_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cfg_soft_rst),
        .load      (load_now),
        .load_word (hold_word_q),
        .mid_tick  (mid_tick),
        .end_tick  (end_tick),
        .miso      (miso),
        .tx_bit    (tx_bit),
        .rx_bits   (rx_bits)
    );

    spi_din_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (miso),
        .dout  (din_level)
    );

    assign sclk  = cfg_cpol ^ (active_q & (phase_hi ^ cfg_cpha));
    assign mosi  = (cfg_force_do || !active_q) ? cfg_idle_do : tx_bit;
    assign busy  = active_q;
    assign done  = done_q;
    assign rx_lo = rx_lo_q;
    assign rx_hi = rx_hi_q;

endmodule

// File: rtl/spi_shift_core_chk.sv
// Property checker for the SPI shift engine, bound to every instance.
// Assumes the reset is synchronous and active low.
module spi_shift_core_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_enable,
    input logic cfg_soft_rst,
    input logic cfg_cpol,
    input logic cfg_idle_do,
    input logic cfg_force_do,
    input logic tx_valid,
    input logic tx_ready,
    input logic sclk,
    input logic mosi,
    input logic miso,
    input logic busy,
    input logic done,
    input logic din_level
);

    logic [1:0] cyc_q;

    // Count the first cycles after reset so that history checks start late enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (cyc_q != 2'd3) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cfg_cpol));

    p_mosi_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || cfg_force_do) |-> (mosi == cfg_idle_do));

    p_din_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2) |-> (din_level == $past(miso, 2)));

    p_ready_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |-> !tx_ready);

    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_soft_rst |=> (!busy && !done));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    p_accept_fills_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

endmodule

bind spi_shift_core spi_shift_core_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_enable   (cfg_enable),
    .cfg_soft_rst (cfg_soft_rst),
    .cfg_cpol     (cfg_cpol),
    .cfg_idle_do  (cfg_idle_do),
    .cfg_force_do (cfg_force_do),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .sclk         (sclk),
    .mosi         (mosi),
    .miso         (miso),
    .busy         (busy),
    .done         (done),
    .din_level    (din_level)
);

// File: tb/test_spi_shift_core.sv
module test_spi_shift_core;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic        cfg_soft_rst = 1'b0;
    logic [1:0]  cfg_word_size = 2'b00;
    logic [1:0]  cfg_clk_div = 2'b00;
    logic        cfg_cpol = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic        cfg_idle_do = 1'b0;
    logic        cfg_force_do = 1'b0;
    logic        cfg_ninth_bit = 1'b0;
    logic [15:0] tx_lo = '0;
    logic [15:0] tx_hi = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        sclk;
    logic        mosi;
    logic        miso = 1'b0;
    logic        busy;
    logic        done;
    logic [15:0] rx_lo;
    logic [15:0] rx_hi;
    logic        din_level;

    logic [31:0] tx_slv = '0;
    logic        miso_idle = 1'b0;
    int          total = 0;
    int          bad = 0;
    bit          finished = 1'b0;
    bit          started = 1'b0;

    // Reference model state
    bit          m_hold, m_act, m_done, m_d1, m_d2;
    logic [31:0] m_hword, m_hslv, m_word, m_slv, m_acc;
    int          m_hlen, m_hh, m_hws, m_len, m_h, m_ws, m_t;
    logic [15:0] m_rx_lo, m_rx_hi;

    spi_shift_core i_spi_shift_core (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_soft_rst(cfg_soft_rst),
        .cfg_word_size(cfg_word_size), .cfg_clk_div(cfg_clk_div), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_idle_do(cfg_idle_do), .cfg_force_do(cfg_force_do),
        .cfg_ninth_bit(cfg_ninth_bit), .tx_lo(tx_lo), .tx_hi(tx_hi), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .sclk(sclk), .mosi(mosi), .miso(miso), .busy(busy),
        .done(done), .rx_lo(rx_lo), .rx_hi(rx_hi), .din_level(din_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic send(input logic [15:0] lo, input logic [15:0] hi, input logic [31:0] slv);
        while (!tx_ready) step();
        tx_lo = lo; tx_hi = hi; tx_slv = slv; tx_valid = 1'b1;
        step();
        tx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 3) begin
            step();
            if (busy) quiet = 0; else quiet++;
        end
    endtask

    // Cycle reference model: compare, drive the slave line, advance.
    always @(negedge clk) begin : model
        int per, bidx;
        bit last, pre_hold, exp_sclk, exp_mosi;
        if (started && rst_n && !finished) begin
            per = 2 * m_h;
            exp_sclk = cfg_cpol ^ (m_act && (((m_t % per) >= m_h) ^ cfg_cpha));
            exp_mosi = (cfg_force_do || !m_act) ? cfg_idle_do : m_word[m_len-1-(m_t/per)];
            chk(busy == m_act, "R1/R10 busy", 32'(busy), 32'(m_act));
            chk(sclk == exp_sclk, "R3/R4 sclk", 32'(sclk), 32'(exp_sclk));
            chk(mosi == exp_mosi, "R2/R5 mosi", 32'(mosi), 32'(exp_mosi));
            chk(done == m_done, "R10 done", 32'(done), 32'(m_done));
            chk({rx_hi, rx_lo} == {m_rx_hi, m_rx_lo}, "R4/R6 rx", {rx_hi, rx_lo}, {m_rx_hi, m_rx_lo});
            chk(tx_ready == (cfg_enable && !m_hold && !cfg_soft_rst), "R8 ready",
                32'(tx_ready), 32'(cfg_enable && !m_hold && !cfg_soft_rst));
            chk(din_level == m_d2, "R7 din", 32'(din_level), 32'(m_d2));
        end
        if (m_act) begin
            per = 2 * m_h; bidx = m_t / per;
            miso = m_slv[m_len-1-bidx];
        end else begin
            miso = miso_idle;
        end
        if (!rst_n) begin
            m_hold = 0; m_act = 0; m_done = 0; m_d1 = 0; m_d2 = 0; m_t = 0;
            m_h = 1; m_len = 8; m_acc = 0; m_rx_lo = 0; m_rx_hi = 0; m_word = 0; m_slv = 0;
            started = 1;
        end else begin
            m_d2 = m_d1; m_d1 = miso;
            if (cfg_soft_rst) begin
                m_hold = 0; m_act = 0; m_done = 0; m_t = 0; m_acc = 0; m_rx_lo = 0; m_rx_hi = 0;
            end else begin
                pre_hold = m_hold; last = 0; m_done = 0;
                if (m_act) begin
                    per = 2 * m_h;
                    if ((m_t % per) == m_h - 1) m_acc = {m_acc[30:0], miso};
                    last = (m_t == per * m_len - 1);
                end
                if (last) begin
                    m_done = 1;
                    if (m_ws == 2) begin m_rx_hi = m_acc[31:16]; m_rx_lo = m_acc[15:0]; end
                    else if (m_ws == 1) m_rx_lo = m_acc[15:0];
                    else m_rx_lo[7:0] = m_acc[7:0];
                end
                if (m_act && !last) m_t++;
                if (pre_hold && (!m_act || last)) begin
                    m_act = 1; m_t = 0; m_len = m_hlen; m_h = m_hh; m_word = m_hword;
                    m_ws = m_hws; m_slv = m_hslv; m_acc = 0; m_hold = 0;
                end else if (last) begin
                    m_act = 0;
                end
                if (tx_valid && cfg_enable && !pre_hold) begin
                    m_hold = 1; m_hws = int'(cfg_word_size); m_hslv = tx_slv;
                    case (cfg_clk_div) 2'b00: m_hh = 4; 2'b01: m_hh = 2; 2'b10: m_hh = 1; default: m_hh = 7; endcase
                    case (cfg_word_size)
                        2'b00: begin m_hlen = 8;  m_hword = {24'b0, tx_lo[7:0]}; end
                        2'b01: begin m_hlen = 16; m_hword = {16'b0, tx_lo}; end
                        2'b10: begin m_hlen = 32; m_hword = {tx_hi, tx_lo}; end
                        default: begin m_hlen = 9; m_hword = {23'b0, cfg_ninth_bit, tx_lo[7:0]}; end
                    endcase
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog R10 act=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin : stim
        int n;
        repeat (3) step();
        // R11: state held by reset
        chk(!busy && !done, "R11 busy/done", {busy, done}, 0);
        chk(rx_lo == 0 && rx_hi == 0, "R11 rx", {rx_hi, rx_lo}, 0);
        chk(din_level == 0, "R11 din", 32'(din_level), 0);
        rst_n = 1'b1; cfg_enable = 1'b1;
        step();

        // 8-bit, divide by 8, mode 0, idle high
        cfg_word_size = 2'b00; cfg_clk_div = 2'b00; cfg_idle_do = 1'b1;
        send(16'h00A5, 16'h0, 32'h3C);
        wait_idle();
        chk(rx_lo[7:0] == 8'h3C, "R6 rx8", 32'(rx_lo), 32'h3C);

        // 16-bit, divide by 4, idle-high clock, phase 0
        cfg_word_size = 2'b01; cfg_clk_div = 2'b01; cfg_cpol = 1'b1; cfg_idle_do = 1'b0;
        send(16'hBEEF, 16'h0, 32'h1234);
        wait_idle();
        chk(rx_lo == 16'h1234, "R6 rx16", 32'(rx_lo), 32'h1234);

        // R6: 8-bit word keeps the upper receive byte
        cfg_word_size = 2'b00;
        send(16'h0011, 16'h0, 32'h5A);
        wait_idle();
        chk(rx_lo == 16'h125A, "R6 stale upper byte", 32'(rx_lo), 32'h125A);

        // 32-bit, divide by 2, phase 1, back-to-back
        cfg_word_size = 2'b10; cfg_clk_div = 2'b10; cfg_cpol = 1'b0; cfg_cpha = 1'b1;
        send(16'hF00D, 16'hCAFE, 32'h89AB_CDEF);
        send(16'h1234, 16'h0F0F, 32'h0F0F_1234);
        wait_idle();
        chk({rx_hi, rx_lo} == 32'h0F0F_1234, "R6 rx32", {rx_hi, rx_lo}, 32'h0F0F_1234);

        // 9-bit, divide by 14, mode 3; R1 busy length 2*7*9
        cfg_word_size = 2'b11; cfg_clk_div = 2'b11; cfg_cpol = 1'b1; cfg_ninth_bit = 1'b1;
        send(16'h0081, 16'h0, 32'h1AA);
        n = 0;
        while (!busy) step();
        while (busy) begin n++; step(); end
        chk(n == 126, "R1 busy length 9-bit /14", 32'(n), 32'd126);
        chk(rx_lo[7:0] == 8'hAA, "R2/R6 rx9", 32'(rx_lo), 32'hAA);
        cfg_ninth_bit = 1'b0;
        send(16'h00FF, 16'h0, 32'h055);
        wait_idle();

        // R5: forced data-out while shifting
        cfg_word_size = 2'b00; cfg_clk_div = 2'b00; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_idle_do = 1'b1;
        send(16'h0000, 16'h0, 32'h81);
        repeat (6) step();
        cfg_force_do = 1'b1;
        step();
        chk(busy && mosi == 1'b1, "R5 forced mosi", {busy, mosi}, 32'h3);
        repeat (5) step();
        cfg_force_do = 1'b0;
        wait_idle();

        // R8: disable with one word in flight and one held
        cfg_word_size = 2'b01; cfg_clk_div = 2'b10;
        send(16'h1111, 16'h0, 32'hAAAA);
        send(16'h2222, 16'h0, 32'h5555);
        cfg_enable = 1'b0;
        step();
        chk(!tx_ready, "R8 ready low when disabled", 32'(tx_ready), 0);
        wait_idle();
        chk(rx_lo == 16'h5555, "R8 drained second word", 32'(rx_lo), 32'h5555);

        // R9: abort in the middle of a word
        cfg_enable = 1'b1; cfg_word_size = 2'b10; cfg_clk_div = 2'b00;
        send(16'hAAAA, 16'h5555, 32'hFFFF_0000);
        repeat (20) step();
        cfg_soft_rst = 1'b1;
        step();
        chk(!busy && !done && rx_lo == 0 && rx_hi == 0, "R9 abort clears", {busy, done, rx_lo[13:0]}, 0);
        cfg_soft_rst = 1'b0;
        step();
        chk(cfg_word_size == 2'b10 && tx_ready, "R9 config kept", {cfg_word_size, tx_ready}, 32'h5);
        send(16'h0F0F, 16'hF0F0, 32'h1357_9BDF);
        wait_idle();
        chk({rx_hi, rx_lo} == 32'h1357_9BDF, "R9 works after abort", {rx_hi, rx_lo}, 32'h1357_9BDF);

        // R7: data-in level while idle
        miso_idle = 1'b1;
        repeat (4) step();
        chk(din_level == 1'b1, "R7 din high", 32'(din_level), 1);
        miso_idle = 1'b0;
        repeat (4) step();

        finished = 1;
        summary();
        $finish;
    end

endmodule